// File: doc/BRIEF.md
# Processor Status Word with Maskable Interrupt Gate

This block holds the 16-bit status word of a processor core. The word carries four arithmetic result flags, two spare control bits, an interrupt enable bit, a stack-select bit and a 3-bit processor priority level. An execution unit updates the arithmetic flags one at a time, each with its own write enable. Software can also load the whole word through a single write port.

From the current word the block decides whether a pending maskable interrupt may be taken. Interrupt events clear the enable bit and the stack-select bit on their own, so the handler starts with interrupts masked and on the interrupt stack. A software interrupt clears the stack-select bit only when its vector number is below a threshold.

Top module: `stw_status_unit`

## Requirements
- R1: A low `rst_n` at a clock edge clears the whole word to 0x0000, whatever the other inputs do.
- R2: Bits 8, 9, 10, 11 and 15 always read 0, and writes to them have no effect.
- R3: When `wr_en` is high at a clock edge, the word becomes `wr_data` with the reserved bits forced to 0. The writable mask is 0x70FF.
- R4: The carry (bit 0), zero (bit 2) and sign (bit 3) flags each take their `alu_*` value at an edge where their own enable is high. This flag update wins over a full-word write in the same cycle. A flag whose enable is low keeps its value.
- R5: The overflow flag (bit 5) takes `alu_ovf` at an edge where `alu_ovf_we` is high, whether the value is set or cleared.
- R6: `irq_accept` is combinational. It is high only when `irq_pending` is high, the enable bit (bit 6) is 1, and the priority comparison of R7 passes.
- R7: The request priority `irq_level` must be strictly greater than the level field in bits 14:12. An equal level is refused, and a level field of 7 blocks every request.
- R8: `irq_ack` clears bit 6 and bit 7 at the next edge. This clear overrides a full-word write to those bits in the same cycle. Other bits follow their normal update.
- R9: A `swi_valid` pulse with `swi_vector` below `SWI_CLR_LIMIT` (32) clears bit 7. A vector of 32 or above leaves bit 7 unchanged. A software interrupt never changes bit 6.
- R10: `user_stack_sel` always equals bit 7 of the word. 1 selects the user stack and 0 selects the interrupt stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alu_carry | input | 1 | Carry result |
| alu_carry_we | input | 1 | Carry update enable |
| alu_zero | input | 1 | Zero result |
| alu_zero_we | input | 1 | Zero update enable |
| alu_sign | input | 1 | Sign result |
| alu_sign_we | input | 1 | Sign update enable |
| alu_ovf | input | 1 | Overflow result |
| alu_ovf_we | input | 1 | Overflow update enable |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 16 | Full-word write value |
| irq_pending | input | 1 | Maskable interrupt request present |
| irq_level | input | 3 | Priority of the request |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| swi_valid | input | 1 | Software interrupt strobe |
| swi_vector | input | VEC_W (6) | Software interrupt vector number |
| status_q | output | 16 | Current status word |
| user_stack_sel | output | 1 | 1 selects the user stack, 0 the interrupt stack |
| irq_accept | output | 1 | Pending request may be taken |

## Verification
The bench builds the block with its defaults: `VEC_W` = 6 and `SWI_CLR_LIMIT` = 32. The 6-bit vector reaches numbers on both sides of the threshold, so vectors 0, 31, 32 and 40 all exercise R9. The 3-bit level covers the equal, one-above and top-level cases of R7. A full-word write is driven in the same cycle as flag updates and as an acknowledge, which shows the precedence rules of R4 and R8.

// File: rtl/stw_pkg.sv
// Package: shared layout of the status word.
// Assumes a fixed 16-bit word; positions matter to the decode in the units below.
package stw_pkg;
    localparam int unsigned WORD_W  = 16;
    localparam int unsigned LVL_W   = 3;
    localparam int unsigned LVL_LSB = 12;
    localparam int unsigned BIT_IE  = 6;
    localparam int unsigned BIT_US  = 7;
    localparam int unsigned N_FLAG  = 4;
    // Flag index order: 0 carry, 1 zero, 2 sign, 3 overflow.
    localparam int unsigned FLAG_POS [N_FLAG] = '{0, 2, 3, 5};
    localparam logic [WORD_W-1:0] WRITABLE_MASK = 16'h70FF;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [N_FLAG-1:0] flagvec_t;
endpackage

// File: rtl/stw_merge.sv
// Module: builds the candidate next word from a full write and flag updates.
// Assumes flag updates win over the full write; reserved bits are masked later.
module stw_merge
    import stw_pkg::*;
(
    input  word_t    cur_word,
    input  logic     wr_en,
    input  word_t    wr_data,
    input  flagvec_t flag_val,
    input  flagvec_t flag_we,
    output word_t    merged
);
    // Purpose: choose base word, then overlay enabled execution flags.
    always_comb begin
        merged = wr_en ? wr_data : cur_word;
        for (int k = 0; k < int'(N_FLAG); k++) begin
            if (flag_we[k]) merged[FLAG_POS[k]] = flag_val[k];
        end
    end
endmodule

// File: rtl/stw_event_clear.sv
// Module: forms the clear mask driven by interrupt events.
// Assumes an acknowledge clears enable and stack select; a low software vector clears stack select.
module stw_event_clear
    import stw_pkg::*;
#(
    parameter int unsigned VEC_W         = 6,
    parameter int unsigned SWI_CLR_LIMIT = 32
) (
    input  logic             irq_ack,
    input  logic             swi_valid,
    input  logic [VEC_W-1:0] swi_vector,
    output word_t            clr_mask
);
    localparam logic [VEC_W:0] LIMIT_V = (VEC_W+1)'(SWI_CLR_LIMIT);

    logic swi_low;

    // Purpose: detect a software vector inside the clearing range.
    always_comb swi_low = swi_valid && ({1'b0, swi_vector} < LIMIT_V);

    // Purpose: set the mask bits the events force to zero.
    always_comb begin
        clr_mask         = '0;
        clr_mask[BIT_IE] = irq_ack;
        clr_mask[BIT_US] = irq_ack | swi_low;
    end
endmodule

// File: rtl/stw_irq_gate.sv
// Module: decides whether a pending maskable request may be taken.
// Assumes a strict greater-than compare against the held level.
module stw_irq_gate
    import stw_pkg::*;
(
    input  logic             irq_pending,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [LVL_W-1:0] cur_level,
    input  logic             ie_bit,
    output logic             accept
);
    // Purpose: combine request, enable and priority compare.
    always_comb accept = irq_pending && ie_bit && (irq_level > cur_level);
endmodule

// File: rtl/stw_status_unit.sv
// Module: top of the status word; holds the register and wires the units.
// Assumes synchronous active-low reset and a combinational accept output.
module stw_status_unit
    import stw_pkg::*;
#(
    parameter int unsigned VEC_W         = 6,
    parameter int unsigned SWI_CLR_LIMIT = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alu_carry,
    input  logic                 alu_carry_we,
    input  logic                 alu_zero,
    input  logic                 alu_zero_we,
    input  logic                 alu_sign,
    input  logic                 alu_sign_we,
    input  logic                 alu_ovf,
    input  logic                 alu_ovf_we,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 irq_pending,
    input  logic [LVL_W-1:0]     irq_level,
    input  logic                 irq_ack,
    input  logic                 swi_valid,
    input  logic [VEC_W-1:0]     swi_vector,
    output logic [WORD_W-1:0]    status_q,
    output logic                 user_stack_sel,
    output logic                 irq_accept
);
    word_t    word_r;
    word_t    merged;
    word_t    clr_mask;
    word_t    word_nx;
    flagvec_t flag_val;
    flagvec_t flag_we;

    // Purpose: pack execution flags in the package index order.
    always_comb begin
        flag_val = {alu_ovf, alu_sign, alu_zero, alu_carry};
        flag_we  = {alu_ovf_we, alu_sign_we, alu_zero_we, alu_carry_we};
    end

    stw_merge u_merge (
        .cur_word (word_r),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .flag_val (flag_val),
        .flag_we  (flag_we),
        .merged   (merged)
    );

    stw_event_clear #(
        .VEC_W         (VEC_W),
        .SWI_CLR_LIMIT (SWI_CLR_LIMIT)
    ) u_clear (
        .irq_ack    (irq_ack),
        .swi_valid  (swi_valid),
        .swi_vector (swi_vector),
        .clr_mask   (clr_mask)
    );

    // Purpose: apply event clears and drop reserved bits.
    always_comb word_nx = merged & ~clr_mask & WRITABLE_MASK;

    // Purpose: hold the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) word_r <= '0;
        else        word_r <= word_nx;
    end

    stw_irq_gate u_gate (
        .irq_pending (irq_pending),
        .irq_level   (irq_level),
        .cur_level   (word_r[LVL_LSB +: LVL_W]),
        .ie_bit      (word_r[BIT_IE]),
        .accept      (irq_accept)
    );

    // Purpose: drive the register value and stack select outputs.
    always_comb begin
        status_q       = word_r;
        user_stack_sel = word_r[BIT_US];
    end
endmodule

// File: rtl/stw_checker.sv
// Module: property checks on the status word, bound to the top.
// Assumes the same parameters as the top it watches.
module stw_checker
    import stw_pkg::*;
#(
    parameter int unsigned VEC_W         = 6,
    parameter int unsigned SWI_CLR_LIMIT = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alu_carry,
    input logic              alu_carry_we,
    input logic              alu_ovf,
    input logic              alu_ovf_we,
    input logic              wr_en,
    input logic [LVL_W-1:0]  irq_level,
    input logic              irq_ack,
    input logic              swi_valid,
    input logic [VEC_W-1:0]  swi_vector,
    input logic [WORD_W-1:0] status_q,
    input logic              user_stack_sel,
    input logic              irq_accept
);
    localparam logic [VEC_W:0] LIMIT_V = (VEC_W+1)'(SWI_CLR_LIMIT);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> status_q == '0);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~WRITABLE_MASK) == '0);

    p_carry_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alu_carry_we |=> status_q[FLAG_POS[0]] == $past(alu_carry));

    p_ovf_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        alu_ovf_we |=> status_q[FLAG_POS[3]] == $past(alu_ovf));

    p_accept_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |-> status_q[BIT_IE]);

    p_accept_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |-> irq_level > status_q[LVL_LSB +: LVL_W]);

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !status_q[BIT_IE] && !user_stack_sel);

    p_swi_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (swi_valid && ({1'b0, swi_vector} < LIMIT_V)) |=> !user_stack_sel);

    p_swi_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (swi_valid && ({1'b0, swi_vector} >= LIMIT_V) && !irq_ack && !wr_en)
        |=> user_stack_sel == $past(user_stack_sel));

    p_swi_keeps_ie_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (swi_valid && !irq_ack && !wr_en) |=> $stable(status_q[BIT_IE]));
endmodule

bind stw_status_unit stw_checker #(
    .VEC_W         (VEC_W),
    .SWI_CLR_LIMIT (SWI_CLR_LIMIT)
) u_stw_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .alu_carry      (alu_carry),
    .alu_carry_we   (alu_carry_we),
    .alu_ovf        (alu_ovf),
    .alu_ovf_we     (alu_ovf_we),
    .wr_en          (wr_en),
    .irq_level      (irq_level),
    .irq_ack        (irq_ack),
    .swi_valid      (swi_valid),
    .swi_vector     (swi_vector),
    .status_q       (status_q),
    .user_stack_sel (user_stack_sel),
    .irq_accept     (irq_accept)
);

// File: tb/test_stw_status_unit.sv
`timescale 1ns/1ps
module test_stw_status_unit;
    localparam int unsigned VEC_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alu_carry = 0, alu_carry_we = 0, alu_zero = 0, alu_zero_we = 0;
    logic alu_sign = 0, alu_sign_we = 0, alu_ovf = 0, alu_ovf_we = 0;
    logic wr_en = 0;
    logic [15:0] wr_data = '0;
    logic irq_pending = 0;
    logic [2:0] irq_level = '0;
    logic irq_ack = 0, swi_valid = 0;
    logic [VEC_W-1:0] swi_vector = '0;
    logic [15:0] status_q;
    logic user_stack_sel, irq_accept;

    typedef struct { logic [15:0] word; string tag; } exp_t;
    exp_t sb_q[$];
    logic [15:0] model_q = '0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    stw_status_unit i_stw_status_unit (
        .clk(clk), .rst_n(rst_n),
        .alu_carry(alu_carry), .alu_carry_we(alu_carry_we),
        .alu_zero(alu_zero), .alu_zero_we(alu_zero_we),
        .alu_sign(alu_sign), .alu_sign_we(alu_sign_we),
        .alu_ovf(alu_ovf), .alu_ovf_we(alu_ovf_we),
        .wr_en(wr_en), .wr_data(wr_data),
        .irq_pending(irq_pending), .irq_level(irq_level),
        .irq_ack(irq_ack), .swi_valid(swi_valid), .swi_vector(swi_vector),
        .status_q(status_q), .user_stack_sel(user_stack_sel), .irq_accept(irq_accept)
    );

    // Reference next word taken from the requirements.
    function automatic logic [15:0] model_next();
        logic [15:0] n;
        if (!rst_n) return 16'h0000;
        n = wr_en ? wr_data : model_q;
        if (alu_carry_we) n[0] = alu_carry;
        if (alu_zero_we)  n[2] = alu_zero;
        if (alu_sign_we)  n[3] = alu_sign;
        if (alu_ovf_we)   n[5] = alu_ovf;
        if (irq_ack) begin n[6] = 1'b0; n[7] = 1'b0; end
        if (swi_valid && swi_vector < 32) n[7] = 1'b0;
        return n & 16'h70FF;
    endfunction

    task automatic idle();
        alu_carry_we = 0; alu_zero_we = 0; alu_sign_we = 0; alu_ovf_we = 0;
        wr_en = 0; irq_ack = 0; swi_valid = 0; irq_pending = 0;
    endtask

    // Driver: one clock with current inputs, expected word pushed to scoreboard.
    task automatic step(input string tag);
        logic [15:0] nx;
        nx = model_next();
        @(posedge clk);
        sb_q.push_back('{word: nx, tag: tag});
        model_q = nx;
        @(negedge clk);
        idle();
    endtask

    task automatic do_write(input logic [15:0] d, input string tag);
        wr_en = 1; wr_data = d;
        step(tag);
    endtask

    task automatic check_accept(input logic pend, input logic [2:0] lvl,
                                input logic exp, input string tag);
        irq_pending = pend; irq_level = lvl;
        #0.5;
        checks++;
        if (irq_accept !== exp) begin
            fails++;
            $display("FAIL %s irq_accept actual=%b expected=%b", tag, irq_accept, exp);
        end
        irq_pending = 0;
    endtask

    // Monitor: pops expected words and compares them with the outputs.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (status_q !== e.word) begin
                    fails++;
                    $display("FAIL %s status_q actual=%h expected=%h", e.tag, status_q, e.word);
                end
                checks++;
                if (user_stack_sel !== e.word[7]) begin
                    fails++;
                    $display("FAIL R10 user_stack_sel actual=%b expected=%b", user_stack_sel, e.word[7]);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset overrides a write
        wr_en = 1; wr_data = 16'hFFFF; step("R1 reset");
        check_accept(1, 3'd7, 0, "R6 in reset");
        rst_n = 1;
        do_write(16'hFFFF, "R3 R2 full write");
        do_write(16'h8F00, "R2 reserved only");
        check_accept(1, 3'd7, 0, "R6 enable low");
        do_write(16'h0040, "R3 enable set");
        check_accept(1, 3'd1, 1, "R6 level1 over 0");
        check_accept(1, 3'd0, 0, "R7 equal 0");
        check_accept(0, 3'd7, 0, "R6 no pending");
        do_write(16'h3040, "R3 level 3");
        check_accept(1, 3'd3, 0, "R7 equal 3");
        check_accept(1, 3'd4, 1, "R7 one above");
        do_write(16'h7040, "R3 level 7");
        check_accept(1, 3'd7, 0, "R7 level 7 blocks");
        do_write(16'h30C0, "R3 enable and user stack");
        irq_ack = 1; wr_en = 1; wr_data = 16'h00C0; step("R8 ack over write");
        check_accept(1, 3'd7, 0, "R8 accept after ack");
        do_write(16'h70FF, "R3 all writable");
        irq_ack = 1; step("R8 ack alone");
        wr_en = 1; wr_data = 16'h0000;
        alu_carry_we = 1; alu_carry = 1; alu_zero_we = 1; alu_zero = 1;
        step("R4 flags over write");
        wr_en = 1; wr_data = 16'h0001; alu_carry_we = 1; alu_carry = 0;
        step("R4 carry clear over write");
        alu_ovf_we = 1; alu_ovf = 1; step("R5 overflow set");
        alu_sign_we = 1; alu_sign = 1; step("R4 sign set");
        alu_ovf_we = 1; alu_ovf = 0; step("R5 overflow clear");
        alu_carry = 1; alu_zero = 0; step("R4 no enable");
        do_write(16'h00C0, "R3 prep swi");
        swi_valid = 1; swi_vector = 6'd40; step("R9 vector 40 keeps");
        swi_valid = 1; swi_vector = 6'd32; step("R9 vector 32 keeps");
        swi_valid = 1; swi_vector = 6'd31; step("R9 vector 31 clears");
        do_write(16'h00C0, "R3 prep swi 0");
        swi_valid = 1; swi_vector = 6'd0; step("R9 vector 0 clears");
        do_write(16'h70FF, "R3 before reset");
        rst_n = 0; step("R1 mid-run reset");
        rst_n = 1;
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule